// File: doc/BRIEF.md
# Split-Pump Bank Peripheral De-stress Controller

This block governs the two supply pumps that feed one memory bank's peripheral circuitry: a read pump, which powers the sense amplifier and the verify logic, and a write pump, which powers the pulse shaper. Turning a pump off for a time puts the sub-blocks it feeds into a de-stress period, during which transistor wear partly recovers. In decoupled operation each pump can be discharged on its own, so only part of the bank is taken out of service. In coupled operation any request turns off both pumps together.

The request scheduler sends per-sub-block de-stress requests and one read or write command at a time. The block accepts a command only when the sub-block the command needs is powered. It emits a start pulse for each read, for each write's program step and for each write's verify step. A write can start its program step while the read pump is off. Its verify step is then held until the read pump is back, and it goes out before any new command is taken. The length of each de-stress period is given on an input, in cycles.

Top module: `subblock_destress_ctrl`

## Requirements
- R1: Synchronous active-high reset leaves both pumps enabled, all three status bits clear, all start pulses low, and no verify pending.
- R2: In decoupled mode, a request on `ds_req[0]` (pulse shaper) clears `wr_pump_en` from the next cycle. The status bit `blk_ds[0]` is then set, and `blk_ds[2:1]` stays clear while the read pump is on.
- R3: In decoupled mode, a request on `ds_req[1]` (verify) or `ds_req[2]` (sense amplifier) clears `rd_pump_en` from the next cycle. It sets both `blk_ds[1]` and `blk_ds[2]`, because they share the read pump. `wr_pump_en` is not affected.
- R4: Requests for both pumps in the same cycle discharge both pumps together.
- R5: In coupled mode (`DECOUPLED=0`), a request on any bit of `ds_req` discharges both pumps, and the two enables are always equal.
- R6: A pump stays off for exactly `ds_len` cycles, with `ds_len` sampled when the de-stress starts and 0 treated as 1. Requests that arrive while that pump is already off have no effect and do not extend the period.
- R7: A read (`cmd_write=0`) is accepted only while the read pump is on. `read_start` pulses for one cycle in the cycle after acceptance.
- R8: A write (`cmd_write=1`) is accepted only while the write pump is on. `prog_start` pulses in the cycle after acceptance. If the read pump is on then, `verify_start` pulses in the following cycle.
- R9: A write accepted while the read pump is off still gives `prog_start` in the next cycle. Its `verify_start` comes in the cycle after the read pump is enabled again, and never while that pump is off.
- R10: While a verify is pending, `cmd_ready` is low for both command types. A read-pump de-stress request in the cycle the pending verify is issued is dropped.
- R11: A de-stress that starts in a cycle takes priority over a command needing the same pump: `cmd_ready` is low for that command in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ds_req | input | 3 | De-stress requests: bit 0 pulse shaper, bit 1 verify, bit 2 sense amplifier |
| ds_len | input | LEN_W | De-stress length in cycles, sampled at start (0 means 1) |
| cmd_valid | input | 1 | A command is offered |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_ready | output | 1 | Offered command is accepted this cycle |
| rd_pump_en | output | 1 | Read pump enable (sense amplifier and verify supply) |
| wr_pump_en | output | 1 | Write pump enable (pulse shaper supply) |
| blk_ds | output | 3 | De-stress status per sub-block, same bit order as `ds_req` |
| read_start | output | 1 | One-cycle pulse starting a read |
| prog_start | output | 1 | One-cycle pulse starting a write's program step |
| verify_start | output | 1 | One-cycle pulse starting a write's verify step |

## Verification
The bench sends a write while the sense amplifier is being de-stressed. A design that issued verify too early would pulse `verify_start` with the read pump off, and one that lost the pending state would never pulse it. It retriggers a pump that is already off and checks that the enable returns after the original length; a design that restarted its timer would stay dark longer. It raises a read-pump request in the cycle a pending verify is issued, and offers commands in the same cycle a de-stress begins. Wrong priority shows as a missing verify pulse or as a command accepted just before its supply is cut. A second instance in coupled mode checks that a pulse-shaper-only request discharges both pumps.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int NBLK    = 3;
  localparam int BLK_PS  = 0;
  localparam int BLK_VF  = 1;
  localparam int BLK_SA  = 2;
  localparam int NPUMP   = 2;
  localparam int PUMP_RD = 0;
  localparam int PUMP_WR = 1;
  typedef logic [NBLK-1:0] blk_vec_t;
endpackage

// File: rtl/sdc_pump_timer.sv
module sdc_pump_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  output logic             pump_en
);
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_en <= 1'b1;
      remain  <= '0;
    end else if (pump_en) begin
      if (go) begin
        pump_en <= 1'b0;
        remain  <= (len == '0) ? '0 : len - LEN_W'(1);
      end
    end else if (remain == '0) begin
      pump_en <= 1'b1;
    end else begin
      remain <= remain - LEN_W'(1);
    end
  end

  // R6: a started de-stress turns the pump off on the next cycle
  assert_start_off_R6: assert property (@(posedge clk) disable iff (rst)
    (go && pump_en) |=> !pump_en);

  // R6: a de-stress in progress runs until its countdown reaches zero
  assert_hold_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!pump_en && remain != '0) |=> !pump_en);
endmodule

// File: rtl/sdc_write_seq.sv
module sdc_write_seq (
  input  logic clk,
  input  logic rst,
  input  logic cmd_valid,
  input  logic cmd_write,
  input  logic rd_en,
  input  logic wr_en,
  input  logic rd_go,
  input  logic wr_go,
  output logic cmd_ready,
  output logic vfy_pend,
  output logic read_start,
  output logic prog_start,
  output logic verify_start
);
  logic take_rd, take_wr, vfy_fire;

  always_comb begin
    if (vfy_pend)       cmd_ready = 1'b0;
    else if (cmd_write) cmd_ready = wr_en & ~wr_go;
    else                cmd_ready = rd_en & ~rd_go;
  end

  assign take_rd  = cmd_valid & cmd_ready & ~cmd_write;
  assign take_wr  = cmd_valid & cmd_ready &  cmd_write;
  assign vfy_fire = vfy_pend & rd_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      vfy_pend     <= 1'b0;
      read_start   <= 1'b0;
      prog_start   <= 1'b0;
      verify_start <= 1'b0;
    end else begin
      read_start   <= take_rd;
      prog_start   <= take_wr;
      verify_start <= vfy_fire;
      vfy_pend     <= (vfy_pend & ~rd_en) | take_wr;
    end
  end

  // R7: a read never starts without the read pump
  assert_read_powered_R7: assert property (@(posedge clk) disable iff (rst)
    read_start |-> rd_en);

  // R8: a program step never starts without the write pump
  assert_prog_powered_R8: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> wr_en);

  // R9: a verify step never starts while the read pump is off
  assert_verify_powered_R9: assert property (@(posedge clk) disable iff (rst)
    verify_start |-> rd_en);

  // R10: each program step is followed by a verify before the next program step
  assert_verify_before_next_R10: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> !$past(vfy_pend));
endmodule

// File: rtl/subblock_destress_ctrl.sv
module subblock_destress_ctrl #(
  parameter int LEN_W     = 8,
  parameter bit DECOUPLED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       ds_req,
  input  logic [LEN_W-1:0] ds_len,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  output logic             cmd_ready,
  output logic             rd_pump_en,
  output logic             wr_pump_en,
  output logic [2:0]       blk_ds,
  output logic             read_start,
  output logic             prog_start,
  output logic             verify_start
);
  import sdc_pkg::*;

  logic [NPUMP-1:0] go_v;
  logic [NPUMP-1:0] en_v;
  logic             vfy_pend;
  logic             vfy_block;
  blk_vec_t         status;

  assign vfy_block = vfy_pend & en_v[PUMP_RD];

  generate
    if (DECOUPLED) begin : g_split
      assign go_v[PUMP_RD] = (ds_req[BLK_SA] | ds_req[BLK_VF]) & en_v[PUMP_RD] & ~vfy_block;
      assign go_v[PUMP_WR] = ds_req[BLK_PS] & en_v[PUMP_WR];
    end else begin : g_joint
      logic joint_go;
      assign joint_go = (|ds_req) & en_v[PUMP_RD] & en_v[PUMP_WR] & ~vfy_block;
      assign go_v[PUMP_RD] = joint_go;
      assign go_v[PUMP_WR] = joint_go;
    end
  endgenerate

  generate
    for (genvar p = 0; p < NPUMP; p++) begin : g_pump
      sdc_pump_timer #(.LEN_W(LEN_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .go      (go_v[p]),
        .len     (ds_len),
        .pump_en (en_v[p])
      );
    end
  endgenerate

  sdc_write_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_write    (cmd_write),
    .rd_en        (en_v[PUMP_RD]),
    .wr_en        (en_v[PUMP_WR]),
    .rd_go        (go_v[PUMP_RD]),
    .wr_go        (go_v[PUMP_WR]),
    .cmd_ready    (cmd_ready),
    .vfy_pend     (vfy_pend),
    .read_start   (read_start),
    .prog_start   (prog_start),
    .verify_start (verify_start)
  );

  always_comb begin
    status         = '0;
    status[BLK_PS] = ~en_v[PUMP_WR];
    status[BLK_VF] = ~en_v[PUMP_RD];
    status[BLK_SA] = ~en_v[PUMP_RD];
  end

  assign rd_pump_en = en_v[PUMP_RD];
  assign wr_pump_en = en_v[PUMP_WR];
  assign blk_ds     = status;

  // R2: a pulse-shaper request with an idle write pump cuts that pump next cycle
  assert_ps_cut_R2: assert property (@(posedge clk) disable iff (rst)
    (ds_req[BLK_PS] && wr_pump_en) |=> !wr_pump_en);

  // R11: an accepted command never loses its pump in the following cycle
  assert_cmd_keeps_pump_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && !cmd_write) |=> rd_pump_en);

  generate
    if (!DECOUPLED) begin : g_chk_joint
      // R5: coupled mode keeps the two pumps in step
      assert_pumps_equal_R5: assert property (@(posedge clk) disable iff (rst)
        rd_pump_en == wr_pump_en);
    end
  endgenerate
endmodule

// File: tb/subblock_destress_ctrl_bench.sv
module subblock_destress_ctrl_bench;
  localparam int LEN_W = 8;

  typedef struct packed {
    logic [2:0]       req;
    logic [LEN_W-1:0] len;
    logic             vld;
    logic             wr;
    logic             e_rdy;
    logic             e_rd;
    logic             e_wrp;
    logic             e_rs;
    logic             e_ps;
    logic             e_vs;
    logic [7:0]       tag;
  } vec_t;

  localparam int NV = 23;
  // fields: req len vld wr | rdy rd wrp rs ps vs | requirement
  localparam vec_t VECS [NV] = '{
    '{3'b000, 8'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 idle
    '{3'b000, 8'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 read
    '{3'b000, 8'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'd8},  // R8 write
    '{3'b000, 8'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd8},  // R8 verify
    '{3'b001, 8'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11}, // R11 R2
    '{3'b000, 8'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 write stalled
    '{3'b000, 8'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd2},  // R2 back, read ok
    '{3'b100, 8'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd9},  // R9 program only
    '{3'b000, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd9},
    '{3'b000, 8'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 read stalled
    '{3'b000, 8'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 length 3
    '{3'b000, 8'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd9},  // R9 deferred verify
    '{3'b010, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 R11 verify req
    '{3'b000, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 zero means one
    '{3'b011, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 both
    '{3'b011, 8'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 ignored
    '{3'b000, 8'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'd8},
    '{3'b100, 8'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd10}, // R10 request dropped
    '{3'b000, 8'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd10},
    '{3'b001, 8'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},
    '{3'b001, 8'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 no extension
    '{3'b000, 8'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},
    '{3'b000, 8'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       ds_req = '0;
  logic [LEN_W-1:0] ds_len = '0;
  logic             cmd_valid = 1'b0;
  logic             cmd_write = 1'b0;
  logic             cmd_ready, rd_pump_en, wr_pump_en;
  logic [2:0]       blk_ds;
  logic             read_start, prog_start, verify_start;

  logic [2:0]       c_req = '0;
  logic             c_ready, c_rd, c_wr, c_rs, c_ps, c_vs;
  logic [2:0]       c_blk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  subblock_destress_ctrl #(.LEN_W(LEN_W), .DECOUPLED(1'b1)) u_subblock_destress_ctrl (
    .clk(clk), .rst(rst), .ds_req(ds_req), .ds_len(ds_len),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_ready(cmd_ready),
    .rd_pump_en(rd_pump_en), .wr_pump_en(wr_pump_en), .blk_ds(blk_ds),
    .read_start(read_start), .prog_start(prog_start), .verify_start(verify_start)
  );

  subblock_destress_ctrl #(.LEN_W(LEN_W), .DECOUPLED(1'b0)) u_coupled (
    .clk(clk), .rst(rst), .ds_req(c_req), .ds_len(ds_len),
    .cmd_valid(1'b0), .cmd_write(1'b0), .cmd_ready(c_ready),
    .rd_pump_en(c_rd), .wr_pump_en(c_wr), .blk_ds(c_blk),
    .read_start(c_rs), .prog_start(c_ps), .verify_start(c_vs)
  );

  task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("reset rd pump", 1, 32'(rd_pump_en), 1);
    chk("reset wr pump", 1, 32'(wr_pump_en), 1);
    chk("reset status", 1, 32'(blk_ds), 0);
    chk("reset pulses", 1, {29'd0, read_start, prog_start, verify_start}, 0);
    chk("reset ready", 1, 32'(cmd_ready), 1);

    for (int i = 0; i < NV; i++) begin
      ds_req    = VECS[i].req;
      ds_len    = VECS[i].len;
      cmd_valid = VECS[i].vld;
      cmd_write = VECS[i].wr;
      #1;
      chk($sformatf("v%0d ready", i), int'(VECS[i].tag), 32'(cmd_ready), 32'(VECS[i].e_rdy));
      @(negedge clk);
      chk($sformatf("v%0d rd pump", i), int'(VECS[i].tag), 32'(rd_pump_en), 32'(VECS[i].e_rd));
      chk($sformatf("v%0d wr pump", i), int'(VECS[i].tag), 32'(wr_pump_en), 32'(VECS[i].e_wrp));
      // R2 R3: status bits 0 PS, 1 verify, 2 sense amp
      chk($sformatf("v%0d status", i), int'(VECS[i].tag), 32'(blk_ds),
          32'({~VECS[i].e_rd, ~VECS[i].e_rd, ~VECS[i].e_wrp}));
      chk($sformatf("v%0d pulses", i), int'(VECS[i].tag),
          {29'd0, read_start, prog_start, verify_start},
          {29'd0, VECS[i].e_rs, VECS[i].e_ps, VECS[i].e_vs});
    end
    ds_req = '0; cmd_valid = 1'b0;

    // R5: coupled instance, pulse-shaper-only request discharges both pumps
    ds_len = 8'd2;
    c_req  = 3'b001;
    @(negedge clk);
    c_req = '0;
    chk("coupled rd off", 5, 32'(c_rd), 0);
    chk("coupled wr off", 5, 32'(c_wr), 0);
    chk("coupled status", 5, 32'(c_blk), 32'h7);
    @(negedge clk);
    chk("coupled still off", 5, {30'd0, c_rd, c_wr}, 0);
    @(negedge clk);
    chk("coupled restored", 5, {30'd0, c_rd, c_wr}, 3);
    // R5: sense-amp request also cuts the write pump
    c_req = 3'b100; ds_len = 8'd1;
    @(negedge clk);
    c_req = '0;
    chk("coupled sa cuts wr", 5, 32'(c_wr), 0);
    @(negedge clk);

    // R1: reset in the middle of a de-stress restores the pumps
    ds_req = 3'b011; ds_len = 8'd9;
    @(negedge clk);
    ds_req = '0;
    chk("pre-reset off", 4, {30'd0, rd_pump_en, wr_pump_en}, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("mid reset pumps", 1, {30'd0, rd_pump_en, wr_pump_en}, 3);
    chk("mid reset status", 1, 32'(blk_ds), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule